// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Bus

This block is a target on a two-wire serial management bus (SMBus / I2C). It holds nine 8-bit configuration registers, numbered 0 to 8, and drives all of them as one flat vector to the logic that uses them. A host can write or read a single register by its index. It can also move the whole set in one block transfer that starts at register 0. Register 7 is a fixed identification byte. The three low bits of register 6 do not come from storage: they always show the strap pins as they are now. Writes to these bits have no effect.

The block samples SCL and SDA with the system clock through a short synchronizer. It decodes start and stop conditions and bit edges from the sampled lines. It pulls SDA low through an open-drain enable, and only while SCL is low. It does not stretch the clock, does not check a packet error code and does not answer a general call.

The first command byte after the address selects the kind of access. Bit 7 set means a single indexed access, with bits 6:0 giving the index. Bit 7 clear means a block access. In a block write the host sends a byte count and then the data. In a block read the target sends the count first and then the data.

Top module: `smb_cfg_target`

## Requirements
- R1: After reset, registers 0..8 read 0xFF, 0xF6, 0xFF, 0x00, 0x07, 0x00, {0x18 with bits 2:0 = strap_i}, 0x08, 0x44.
- R2: Only the 7-bit address 0x69 (0xD2 for write, 0xD3 for read) is acknowledged. For any other address the target leaves SDA released for the ACK bit and for every later bit, and changes no register until a new start condition.
- R3: A byte write consists of address+W, a command with bit 7 = 1 and the index in bits 6:0, and one data byte. It stores the data in the indexed register, and every byte is acknowledged with SDA low.
- R4: A byte read consists of address+W, the command, a repeated start, address+R, and one data byte sent MSB first. That byte is the indexed register. Register 6 bits 2:0 in that byte are the strap inputs at the time of the read.
- R5: Writes to register 7 and to register 6 bits 2:0 have no effect. The other bits of register 6 are written normally.
- R6: A block write consists of address+W, a command of 0x00, a count byte that is acknowledged but never stored, and then data bytes. The data bytes go to registers 0, 1, 2, … in order. A stop after any complete byte leaves the registers that were not reached unchanged.
- R7: A block read consists of address+W, a command of 0x00, a repeated start, and address+R. The target then sends the value 9, followed by registers 0, 1, 2, … in order. Each ACK from the host continues the transfer; a NACK ends it, and the bus is then free for a new transfer.
- R8: Indexes 9 to 127 hold nothing. Writes to them are ignored and reads from them return 0x00. This also applies to block bytes past register 8.
- R9: The SDA drive enable changes only while SCL is low, apart from the release it performs at a start or stop condition.
- R10: regs_o[8*i+7 : 8*i] always carries register i as it would be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| strap_i | input | 3 | Strap levels shown in register 6 bits 2:0 |
| regs_o | output | 72 | All nine registers, register i at bits 8i+7:8i |

## Verification
The bench sweeps byte writes followed by byte reads over every real index, over the two read-only cases and over indexes past the register set. A broken index decode or write mask would then show up as a wrong readback or as a corrupted neighbour in regs_o. It also sends a set of foreign addresses followed by data bytes. A target that acknowledged a near-miss address, or that kept decoding after the NACK, would drive an ACK or change a register. Block writes are run full, cut short after three bytes, and run past the end. A design that stored the count byte, started at the wrong register, or wrapped past register 8 would break the register image. Block reads check the leading count of 9, the order of the data and the zero bytes past the end. They also check that a NACK part-way through returns the bus cleanly for the next transfer.

// File: rtl/smbcfg_pkg.sv
// Shared constants, reset values, write masks and state encodings for the
// two-wire configuration register target. Assumes register 6 carries the
// straps in its low bits and register 7 is a fixed identification byte.
package smbcfg_pkg;

    localparam int            BYTE_W    = 8;
    localparam int            STRAP_W   = 3;
    localparam int            STRAP_REG = 6;
    localparam logic [7:0]    ID_VALUE  = 8'h08;

    // Power-up value of register i
    function automatic logic [7:0] reg_reset(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'hF6;
            2:       return 8'hFF;
            3:       return 8'h00;
            4:       return 8'h07;
            5:       return 8'h00;
            6:       return 8'h18;
            7:       return ID_VALUE;
            8:       return 8'h44;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of register i that the host may change
    function automatic logic [7:0] reg_wmask(input int i);
        case (i)
            STRAP_REG: return 8'hF8;
            7:         return 8'h00;
            default:   return 8'hFF;
        endcase
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK_DRV,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } fsm_t;

    typedef enum logic [1:0] {
        K_ADDR,
        K_CMD,
        K_CNT,
        K_DATA
    } kind_t;

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes the system clock is several times faster than SCL, so that each
// SCL phase lasts more than SYNC_STAGES + 2 clock cycles.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic                   scl_d, sda_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-stage capture of both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            // Shift chain that settles both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    // Previous settled levels, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_q[LAST];
            sda_d <= sda_q[LAST];
        end
    end

    // Event decode from the settled levels
    always_comb begin
        scl       = scl_q[LAST];
        sda       = sda_q[LAST];
        scl_rise  = scl & ~scl_d;
        scl_fall  = ~scl & scl_d;
        start_det = scl & scl_d & sda_d & ~sda;
        stop_det  = scl & scl_d & ~sda_d & sda;
    end

endmodule

// File: rtl/smb_cfg_regfile.sv
// Nine-entry configuration store with per-bit write masks, a fixed ID byte
// and a live strap view in register STRAP_REG. Assumes one write per cycle
// at most; indexes at or above NUM_REGS neither store nor return data.
module smb_cfg_regfile
    import smbcfg_pkg::*;
#(
    parameter int NUM_REGS = 9,
    parameter int IDX_W    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           waddr,
    input  logic [BYTE_W-1:0]          wdata,
    input  logic [IDX_W-1:0]           raddr,
    input  logic [STRAP_W-1:0]         strap,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
    logic [BYTE_W-1:0] q    [NUM_REGS];
    logic [BYTE_W-1:0] view [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            localparam logic [BYTE_W-1:0] RST = reg_reset(g);
            localparam logic [BYTE_W-1:0] WM  = reg_wmask(g);

            // Masked storage for register g
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[g] <= RST;
                else if (we && waddr == IDX_W'(g))
                    q[g] <= (wdata & WM) | (q[g] & ~WM);
            end

            if (g == STRAP_REG) begin : g_strap
                // Strap bits replace the low field of this register
                assign view[g] = {q[g][BYTE_W-1:STRAP_W], strap};
            end else begin : g_plain
                assign view[g] = q[g];
            end

            assign regs_flat[g*BYTE_W +: BYTE_W] = view[g];

            // R3
            wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && waddr == IDX_W'(g)) |=> (((q[g] ^ $past(wdata)) & WM) == '0));
            // R5
            ro_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && waddr == IDX_W'(g)) |=> ((q[g] & ~WM) == ($past(q[g]) & ~WM)));
            // R8
            no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(we && waddr == IDX_W'(g)) |=> (q[g] == $past(q[g])));
        end
    endgenerate

    // Read mux; unmapped indexes return zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (raddr == IDX_W'(i)) rdata = view[i];
    end

endmodule

// File: rtl/smb_target_fsm.sv
// Protocol engine: address match, command decode, indexed and block
// transfers, ACK generation and byte transmission. Assumes event inputs come
// from smb_line_sync and that SCL is never stretched by this target.
module smb_target_fsm
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 9,
    parameter int         IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_oe,
    output logic              we,
    output logic [IDX_W-1:0]  ptr,
    output logic [BYTE_W-1:0] wdata
);
    localparam logic [IDX_W-1:0]  PTR_MAX = '1;
    localparam logic [BYTE_W-1:0] COUNT_B = BYTE_W'(NUM_REGS);

    fsm_t             st;
    kind_t            kind;
    logic [2:0]       bitcnt;
    logic [BYTE_W-1:0] sh;
    logic             blk, rd_dir, first, mack;
    logic [BYTE_W-1:0] rx_byte, tx_next;
    logic             byte_done;
    logic [IDX_W-1:0] ptr_inc;

    // Incoming byte, next outgoing byte and saturating pointer step
    always_comb begin
        rx_byte   = {sh[BYTE_W-2:0], sda};
        byte_done = (st == ST_RX) && scl_rise && (bitcnt == 3'd7);
        tx_next   = (blk && first) ? COUNT_B : rdata;
        ptr_inc   = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;
        we        = byte_done && (kind == K_DATA) && !start_det && !stop_det;
        wdata     = rx_byte;
    end

    // Bus protocol sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sh     <= '0;
            ptr    <= '0;
            blk    <= 1'b0;
            rd_dir <= 1'b0;
            first  <= 1'b0;
            mack   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            st     <= ST_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_det) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_RX: if (scl_rise) begin
                    sh     <= rx_byte;
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        case (kind)
                            K_ADDR: begin
                                if (rx_byte[7:1] == DEV_ADDR) begin
                                    rd_dir <= rx_byte[0];
                                    first  <= 1'b1;
                                    st     <= ST_ACK_WAIT;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end
                            K_CMD: begin
                                blk <= ~rx_byte[7];
                                ptr <= rx_byte[7] ? rx_byte[IDX_W-1:0] : '0;
                                st  <= ST_ACK_WAIT;
                            end
                            K_CNT:   st <= ST_ACK_WAIT;
                            default: begin
                                ptr <= ptr_inc;
                                st  <= ST_ACK_WAIT;
                            end
                        endcase
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    sda_oe <= 1'b1;
                    st     <= ST_ACK_DRV;
                end
                ST_ACK_DRV: if (scl_fall) begin
                    bitcnt <= '0;
                    if (rd_dir) begin
                        sh     <= tx_next;
                        sda_oe <= ~tx_next[BYTE_W-1];
                        if (!(blk && first)) ptr <= ptr_inc;
                        first  <= 1'b0;
                        st     <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                        case (kind)
                            K_ADDR:  kind <= K_CMD;
                            K_CMD:   kind <= blk ? K_CNT : K_DATA;
                            default: kind <= K_DATA;
                        endcase
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (bitcnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        st     <= ST_MACK;
                    end else begin
                        sh     <= sh << 1;
                        sda_oe <= ~sh[BYTE_W-2];
                        bitcnt <= bitcnt + 3'd1;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) mack <= ~sda;
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (mack) begin
                            sh     <= tx_next;
                            sda_oe <= ~tx_next[BYTE_W-1];
                            ptr    <= ptr_inc;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R9
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !scl);

    // R2
    nack_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && kind == K_ADDR && rx_byte[7:1] != DEV_ADDR && !start_det && !stop_det)
        |=> (st == ST_SKIP && !sda_oe));

    // R2
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_RX && kind == K_ADDR && bitcnt == 3'd0));

    // R7
    count_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK_DRV && scl_fall && rd_dir && blk && first && !start_det && !stop_det)
        |=> (sh == COUNT_B));

endmodule

// File: rtl/smb_cfg_target.sv
// Top level of the two-wire configuration register target. Ties the line
// synchronizer, the protocol engine and the register store together.
// Assumes an external open-drain pad: sda_oe = 1 pulls SDA low.
module smb_cfg_target
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    input  logic [STRAP_W-1:0]         strap_i,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int IDX_W = 7;

    logic              scl, sda, scl_rise, scl_fall, start_det, stop_det;
    logic              we;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] wdata, rdata;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl       (scl),
        .sda       (sda),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_target_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl),
        .sda       (sda),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .we        (we),
        .ptr       (ptr),
        .wdata     (wdata)
    );

    smb_cfg_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (ptr),
        .wdata     (wdata),
        .raddr     (ptr),
        .strap     (strap_i),
        .rdata     (rdata),
        .regs_flat (regs_o)
    );

endmodule

// File: tb/tb_smb_cfg_target.sv
// Bench: acts as bus host, keeps its own register model, sweeps indexes,
// addresses and block lengths.
module tb_smb_cfg_target;
    localparam int Q = 6;
    localparam int N = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic        sda_oe;
    logic [2:0]  strap = 3'b101;
    logic [71:0] regs;
    logic        sda_bus;
    int          nchk = 0, nfail = 0;
    bit          done = 1'b0;
    logic [7:0]  exp_q [N];

    assign sda_bus = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    smb_cfg_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_i(strap), .regs_o(regs)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] want);
        nchk++;
        if (got !== want) begin
            nfail++;
            $display("FAIL %s got %02h expected %02h", tag, got, want);
        end
    endtask

    function automatic logic [7:0] wmask(input int i);
        return (i == 7) ? 8'h00 : (i == 6) ? 8'hF8 : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rd(input int i);
        if (i >= N) return 8'h00;
        if (i == 6) return {exp_q[6][7:3], strap};
        return exp_q[i];
    endfunction

    function automatic void model_wr(input int i, input logic [7:0] v);
        if (i < N) exp_q[i] = (v & wmask(i)) | (exp_q[i] & ~wmask(i));
    endfunction

    task automatic chk_image(input string tag);
        for (int i = 0; i < N; i++) chk(tag, regs[i*8 +: 8], exp_rd(i));
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
        end
        m_sda = nack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input int idx, input logic [7:0] v, input string tag);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h80 | 8'(idx), a1);
        send_byte(v, a2);
        bus_stop();
        chk(tag, {5'd0, a0, a1, a2}, 8'h00);
    endtask

    task automatic rd_byte(input int idx, output logic [7:0] v);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h80 | 8'(idx), a1);
        bus_start();
        send_byte(8'hD3, a2);
        recv_byte(1'b1, v);
        bus_stop();
        chk("R4 acks", {5'd0, a0, a1, a2}, 8'h00);
    endtask

    task automatic blk_wr(input int n, input int seed, input string tag);
        logic a, acc;
        acc = 1'b0;
        bus_start();
        send_byte(8'hD2, a); acc |= a;
        send_byte(8'h00, a); acc |= a;
        send_byte(8'(n), a); acc |= a;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'(i * 29 + seed);
            send_byte(d, a); acc |= a;
            model_wr(i, d);
        end
        bus_stop();
        chk(tag, {7'd0, acc}, 8'h00);
    endtask

    task automatic blk_rd(input int n, input string tag);
        logic a0, a1, a2;
        logic [7:0] cnt, v;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte(8'h00, a1);
        bus_start();
        send_byte(8'hD3, a2);
        chk("R7 acks", {5'd0, a0, a1, a2}, 8'h00);
        recv_byte(1'b0, cnt);
        chk("R7 count", cnt, 8'd9);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, v);
            chk(tag, v, exp_rd(i));
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: run did not complete (got hung, expected finish)");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < N; i++) exp_q[i] = (i == 0) ? 8'hFF : (i == 1) ? 8'hF6 :
            (i == 2) ? 8'hFF : (i == 4) ? 8'h07 : (i == 6) ? 8'h18 : (i == 7) ? 8'h08 :
            (i == 8) ? 8'h44 : 8'h00;
        wq(5); rst_n = 1'b1; wq(5);
        // R1 reset image, R10 layout
        chk_image("R1 reset");
        chk("R1 sda released", {7'd0, sda_oe}, 8'h00);

        // R3 / R5 / R8 indexed write then read sweep
        for (int idx = 0; idx < 12; idx++) begin
            int ix;
            string tag;
            ix  = (idx == 11) ? 127 : idx;
            tag = (ix == 6 || ix == 7) ? "R5" : (ix >= N) ? "R8" : "R3";
            v = 8'(ix * 37 + 8'h5A);
            wr_byte(ix, v, tag);
            model_wr(ix, v);
            rd_byte(ix, v);
            chk({tag, " R4 readback"}, v, exp_rd(ix));
            chk_image({tag, " R10 image"});
        end

        // R4 strap change seen live
        strap = 3'b010; wq(4);
        rd_byte(6, v);
        chk("R4 strap", v, exp_rd(6));
        chk_image("R4 strap image");

        // R2 foreign addresses: no ACK, no change
        for (int k = 0; k < 4; k++) begin
            logic [6:0] ad;
            logic a0, a1, a2;
            ad = (k == 0) ? 7'h68 : (k == 1) ? 7'h6B : (k == 2) ? 7'h29 : 7'h7F;
            bus_start();
            send_byte({ad, 1'b0}, a0);
            send_byte(8'h81, a1);
            send_byte(8'h3C, a2);
            bus_stop();
            chk("R2 nack", {5'd0, a0, a1, a2}, 8'h07);
            chk_image("R2 image");
        end

        // R6 full, partial and R8 overlong block writes
        blk_wr(9, 3, "R6 acks full");
        chk_image("R6 full");
        blk_wr(3, 101, "R6 acks partial");
        chk_image("R6 partial");
        blk_wr(11, 57, "R8 acks overlong");
        chk_image("R8 overlong");

        // R7 block read including bytes past the end (R8)
        blk_rd(11, "R7 data");
        // R7 early NACK then an indexed read still works
        blk_rd(2, "R7 short");
        rd_byte(4, v);
        chk("R7 after nack", v, exp_rd(4));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule